// File: doc/BRIEF.md
# Run-Length Zero Decoder for Scan Input

This block sits between a top-level scan input pin and one internal scan chain. It takes fixed-width codewords, each three bits, and expands every codeword into a variable-length serial symbol. The codeword value k sets how many zero bits come out before a single terminating one. The internal chain therefore receives long stretches of zeros while the tester sends only a few bits per symbol.

Codewords arrive on a valid/ready handshake. Once a codeword is taken, the decoder plays its symbol out one bit per clock. Input ready stays low while zeros of the current symbol are still being emitted. Ready comes back in the cycle that shows the terminating one, so a waiting codeword can be taken at that edge and its symbol follows with no idle cycle. The serial output carries a valid flag, and the chain shifts only when that flag is high.

Top module: `rld_decoder`

## Requirements
- R1: A codeword `in_code` (3 bits, unsigned value k from 0 to 7) is accepted at a rising clock edge where both `in_valid` and `in_ready` are high. A codeword presented while `in_ready` is low is not consumed and produces no output.
- R2: An accepted codeword of value k produces k+1 consecutive output cycles with `out_valid` high, starting in the cycle after acceptance. `out_bit` is 0 in the first k of these cycles and 1 in the last.
- R3: `in_ready` is low in every cycle where a zero of the current symbol is on the output. It is high in the cycle that shows the terminating one and whenever no symbol is in progress.
- R4: A codeword accepted in the cycle that shows a terminating one has its first bit in the very next cycle, so back-to-back symbols leave no gap in `out_valid`.
- R5: The long-run codes 6 and 7 emit six and seven zeros respectively, each followed by a one, and they hold off input for the whole run.
- R6: While no symbol is being emitted, `out_valid` is low and `out_bit` is 0.
- R7: Synchronous active-high reset `rst` abandons any run in progress. In the cycle after a reset edge, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Codeword present on `in_code` |
| in_code | input | 3 | Codeword: count of zeros before the terminating one |
| in_ready | output | 1 | Decoder can take a codeword at the next edge |
| out_valid | output | 1 | `out_bit` carries a symbol bit this cycle |
| out_bit | output | 1 | Serial bit for the internal scan chain |

## Verification
A wrong count in the run counter shows up within one symbol. The run either gets a zero too many or too few, and the terminating one lands in the wrong cycle. Ready also returns early or late against the bit stream. The bench models the expected bit queue per accepted codeword and compares `out_valid`, `out_bit` and `in_ready` every cycle. A miscounted or dropped symbol is therefore reported in the first cycle where it diverges, not at the end of a pattern. Gaps between back-to-back symbols and codewords lost while ready is low are caught the same way.

// File: rtl/rld_pkg.sv
package rld_pkg;
  localparam int unsigned CODE_W_DEF = 3;

  // registered serial output of the decoder
  typedef struct packed {
    logic valid;
    logic data;
  } rld_out_t;
endpackage

// File: rtl/rld_run_counter.sv
module rld_run_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] remaining,
  output logic         idle
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign remaining = cnt_q;
  assign idle      = (cnt_q == '0);
endmodule

// File: rtl/rld_emitter.sv
module rld_emitter #(
  parameter int unsigned W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_last,
  input  logic [W-1:0]     remaining,
  output rld_pkg::rld_out_t sout
);
  rld_pkg::rld_out_t out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (start) begin
      out_q.valid <= 1'b1;
      out_q.data  <= start_last;
    end else if (remaining != '0) begin
      out_q.valid <= 1'b1;
      out_q.data  <= (remaining == W'(1));
    end else begin
      out_q <= '0;
    end
  end

  assign sout = out_q;
endmodule

// File: rtl/rld_decoder.sv
module rld_decoder #(
  parameter int unsigned CODE_W = rld_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_bit
);
  logic              idle;
  logic              accept;
  logic [CODE_W-1:0] remaining;
  rld_pkg::rld_out_t sout;

  assign accept   = in_valid && idle;
  assign in_ready = idle;

  rld_run_counter #(.W(CODE_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_val  (in_code),
    .remaining (remaining),
    .idle      (idle)
  );

  rld_emitter #(.W(CODE_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_last (in_code == '0),
    .remaining  (remaining),
    .sout       (sout)
  );

  assign out_valid = sout.valid;
  assign out_bit   = sout.data;
endmodule

// File: rtl/rld_decoder_sva.sv
module rld_decoder_sva #(
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_bit
);
  AST_START_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);                                           // R2
  AST_FIRST_BIT_VALUE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_bit == $past(in_code == '0)));                   // R2
  AST_ZERO_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bit) |-> !in_ready);                                          // R3
  AST_ONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bit) |-> in_ready);                                            // R3
  AST_NONZERO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_code != '0) |=> !in_ready);                          // R5
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bit) |=> out_valid);                                          // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_bit);                                                        // R6
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);                                         // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));                                               // R7
endmodule

bind rld_decoder rld_decoder_sva #(.CODE_W(CODE_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit)
);

// File: tb/sim_rld_decoder.sv
`timescale 1ns/1ps
module sim_rld_decoder;
  localparam int unsigned CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_code = '0;
  logic          in_ready;
  logic          out_valid;
  logic          out_bit;

  int n_checks = 0;
  int n_fails  = 0;
  bit running  = 1'b0;
  bit exp_q[$];

  always #2 clk = ~clk;

  rld_decoder #(.CODE_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected symbol for codeword k: k zeros then a one (R2)
  function automatic int sym_len(input int k);
    return k + 1;
  endfunction

  // cycle model: compare, then enqueue what the coming edge accepts (R1)
  always @(negedge clk) begin
    if (running) begin
      if (rst) begin
        exp_q.delete();
      end else begin
        if (out_valid) begin
          if (exp_q.size() == 0) chk(1'b0, "R6 spurious valid", 1, 0);
          else begin
            bit e;
            e = exp_q.pop_front();
            chk(out_bit == e, "R2 bit", out_bit, e);
          end
        end else begin
          chk(exp_q.size() == 0, "R4 gap in symbol", 0, 1);
          chk(out_bit == 1'b0, "R6 idle bit", out_bit, 0);
        end
        chk(in_ready == (exp_q.size() == 0), "R3 ready", in_ready, exp_q.size() == 0);
        if (in_valid && in_ready)
          for (int i = 0; i < sym_len(int'(in_code)); i++) exp_q.push_back(i == int'(in_code));
      end
    end
  end

  task automatic send(input int code, input int gap);
    repeat (gap) @(posedge clk);
    #1 in_valid = 1'b1; in_code = CW'(code);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2741));
    running = 1'b1;
    do_reset();                                   // R7 reset state
    for (int k = 0; k < 8; k++) send(k, 3);       // R2 every code, idle between
    send(6, 2); send(7, 0);                        // R5 long runs back to back
    send(3, 0); send(0, 0); send(0, 0); send(1, 0); // R4 no gap between symbols
    repeat (10) @(posedge clk);
    // R1: codeword offered while busy and withdrawn is never consumed
    send(5, 0);
    @(posedge clk); #1 in_valid = 1'b1; in_code = 3'd7;
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (12) @(posedge clk);
    // R7: reset in the middle of a long run
    send(7, 0);
    repeat (3) @(posedge clk);
    do_reset();
    repeat (4) @(posedge clk);
    for (int n = 0; n < 400; n++)
      send(int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0);
    repeat (12) @(posedge clk);
    finish_run();
  end
endmodule